// File: doc/BRIEF.md
# Tri-State Phase Comparator with Lock Indicator

This block measures the phase and frequency error between a divided reference pulse train and a divided feedback pulse train. Both trains are sampled in the system clock domain. A rising edge on either one starts an error window that lasts until the rising edge of the other. While the window is open, the block drives a three-state pump control output toward the setting that pulls the loop back into phase. The same error is also given as a push-pull pump-up signal and as an open-drain pump-down signal that can only pull low or float. A swap input exchanges the roles of the two inputs, so the output polarity suits the external filter and oscillator.

A lock indicator rises after a fixed run of short comparisons and falls as soon as one error window grows too long. A run input chooses between active mode and power-save. In power-save the pump outputs float, the lock indicator is forced high, and the detector is held clear, so no stale error survives the return to active mode.

The detector is a three-state machine. Its states are PH_IDLE (no window open), PH_REF_LEAD (reference edge seen, feedback edge pending) and PH_FB_LEAD (feedback edge seen, reference edge pending). The transitions are:
- PH_IDLE goes to PH_REF_LEAD on a reference-only edge and to PH_FB_LEAD on a feedback-only edge. It stays in PH_IDLE when both edges come in the same cycle.
- PH_REF_LEAD returns to PH_IDLE on a feedback edge, and PH_FB_LEAD returns to PH_IDLE on a reference edge.
- Every state goes to PH_IDLE when the run input is low.

Top module: `pcd_phase_cmp`

## Requirements
- R1: With `swap_sel`=0, a reference edge that comes before the feedback edge drives `do_oe`=1 and `do_val`=1. This starts on the clock after the reference edge is sampled and lasts exactly as many clocks as separate the two edges.
- R2: With `swap_sel`=0, a feedback edge that comes first drives `do_oe`=1 and `do_val`=0 for the same window.
- R3: With `swap_sel`=1, the levels are inverted: a reference lead gives `do_val`=0 and a feedback lead gives `do_val`=1, in both cases with `do_oe`=1.
- R4: When both edges are sampled in the same clock, or once the lagging edge arrives, `do_oe`=0 (high-impedance).
- R5: `pu_o` is 1 exactly while `do_oe`=1 and `do_val`=1. `pd_oe` (1 = pull low, otherwise float) is 1 exactly while `do_oe`=1 and `do_val`=0. The two are never 1 together.
- R6: A further edge on the leading input while its window is open has no effect: the window and the output level continue unchanged.
- R7: `lock_o` rises after `LOCK_RUN` (default 4) consecutive comparisons whose window is shorter than `lock_tol` clocks. A same-cycle pair of edges counts as a window of zero clocks.
- R8: As soon as an open window reaches `lock_tol` clocks, `lock_o` falls on the next clock edge and the run of good comparisons starts again from zero.
- R9: With `run_en`=0, `do_oe`=0, `pu_o`=0, `pd_oe`=0 and `lock_o`=1, and input edges are ignored.
- R10: With `run_en`=0, the detector is cleared. After `run_en` returns to 1, the first single edge opens a new window, whatever was pending before power-save.
- R11: After reset with `run_en`=1: `do_oe`=0, `pu_o`=0, `pd_oe`=0, `lock_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse train, in the clk domain |
| fb_in | input | 1 | Divided feedback pulse train, in the clk domain |
| swap_sel | input | 1 | 1 swaps the roles of reference and feedback |
| run_en | input | 1 | 1 = active mode, 0 = power-save |
| lock_tol | input | TOL_W | Lock window limit in clocks (at least 1) |
| do_oe | output | 1 | Three-state pump output drive enable |
| do_val | output | 1 | Three-state pump output level when driven |
| pu_o | output | 1 | Push-pull pump-up signal |
| pd_oe | output | 1 | Open-drain pump-down: 1 pulls low |
| lock_o | output | 1 | Lock indicator |

## Verification
The assertions check the following on every cycle: power-save forces the outputs and clears the detector, the pump-up and pump-down signals never overlap, a same-cycle pair of edges never opens a window, the machine never jumps straight from one lead state to the other, and each rise or fall of the lock indicator has a good or bad comparison just before it. Only the directed scenarios can show the rest. These are the exact window width and its polarity under each swap setting, that a repeated leading edge is ignored, the count of comparisons before lock, the exact clock on which a long window drops lock, and that a pending lead is discarded across power-save.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_REF_LEAD = 2'd1,
        PH_FB_LEAD  = 2'd2
    } ph_state_t;
endpackage

// File: rtl/pcd_rise.sv
module pcd_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
    end
endmodule

// File: rtl/pcd_detector.sv
module pcd_detector
    import pcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output ph_state_t state,
    output logic      lead_end,
    output logic      coincident
);
    ph_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        lead_end   = 1'b0;
        coincident = 1'b0;
        if (!run) begin
            nxt = PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (ref_rise && fb_rise) coincident = 1'b1;
                    else if (ref_rise)       nxt = PH_REF_LEAD;
                    else if (fb_rise)        nxt = PH_FB_LEAD;
                end
                PH_REF_LEAD: begin
                    if (fb_rise) begin
                        nxt      = PH_IDLE;
                        lead_end = 1'b1;
                    end
                end
                PH_FB_LEAD: begin
                    if (ref_rise) begin
                        nxt      = PH_IDLE;
                        lead_end = 1'b1;
                    end
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    AST_PS_CLEARS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == PH_IDLE); // R10
    AST_COINCIDENT_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && run && ref_rise && fb_rise) |=> state == PH_IDLE); // R4
    AST_NO_LEAD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_REF_LEAD |=> state != PH_FB_LEAD); // R6
endmodule

// File: rtl/pcd_lock.sv
module pcd_lock #(
    parameter int TOL_W    = 8,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_lead,
    input  logic             lead_end,
    input  logic             coincident,
    input  logic [TOL_W-1:0] tol,
    output logic             locked
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

    logic [TOL_W-1:0] width_cnt;
    logic [TOL_W:0]   width_now;
    logic [RUN_W-1:0] run_cnt;
    logic             good_ev;
    logic             bad_ev;

    assign width_now = {1'b0, width_cnt} + 1'b1;
    assign bad_ev    = run && in_lead && (width_now == {1'b0, tol});
    assign good_ev   = run && ((lead_end && (width_now < {1'b0, tol})) || coincident);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            width_cnt <= '0;
        else if (!run || !in_lead || lead_end)
            width_cnt <= '0;
        else if (width_cnt != '1)
            width_cnt <= width_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (bad_ev) begin
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (good_ev) begin
            if (run_cnt == RUN_LAST) locked  <= 1'b1;
            else                     run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(good_ev)); // R7
    AST_UNLOCK_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bad_ev)); // R8
endmodule

// File: rtl/pcd_phase_cmp.sv
module pcd_phase_cmp
    import pcd_pkg::*;
#(
    parameter int TOL_W    = 8,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             swap_sel,
    input  logic             run_en,
    input  logic [TOL_W-1:0] lock_tol,
    output logic             do_oe,
    output logic             do_val,
    output logic             pu_o,
    output logic             pd_oe,
    output logic             lock_o
);
    logic [1:0] rise;
    ph_state_t  st;
    logic       lead_end;
    logic       coincident;
    logic       locked;
    logic       up;
    logic       dn;

    pcd_rise #(.W(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({fb_in, ref_in}),
        .rise  (rise)
    );

    pcd_detector u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .ref_rise   (rise[0]),
        .fb_rise    (rise[1]),
        .state      (st),
        .lead_end   (lead_end),
        .coincident (coincident)
    );

    pcd_lock #(.TOL_W(TOL_W), .LOCK_RUN(LOCK_RUN)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .in_lead    (st != PH_IDLE),
        .lead_end   (lead_end),
        .coincident (coincident),
        .tol        (lock_tol),
        .locked     (locked)
    );

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (st)
            PH_REF_LEAD: begin up = !swap_sel; dn = swap_sel;  end
            PH_FB_LEAD:  begin up = swap_sel;  dn = !swap_sel; end
            default:     begin up = 1'b0;      dn = 1'b0;      end
        endcase
        do_oe  = run_en && (up || dn);
        do_val = run_en && up;
        pu_o   = run_en && up;
        pd_oe  = run_en && dn;
        lock_o = locked || !run_en;
    end

    AST_PS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!do_oe && !pu_o && !pd_oe && lock_o)); // R9
    AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pu_o, pd_oe})); // R5
    AST_Z_HAS_NO_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !do_oe |-> (!pu_o && !pd_oe)); // R4
endmodule

// File: tb/sim_pcd_phase_cmp.sv
module sim_pcd_phase_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       swap_sel = 1'b0;
    logic       run_en = 1'b1;
    logic [7:0] lock_tol = 8'd5;
    logic       do_oe, do_val, pu_o, pd_oe, lock_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcd_phase_cmp u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .swap_sel(swap_sel), .run_en(run_en), .lock_tol(lock_tol),
        .do_oe(do_oe), .do_val(do_val), .pu_o(pu_o), .pd_oe(pd_oe), .lock_o(lock_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_in = 0; fb_in = 0; run_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R11 do_oe", do_oe, 0);
        chk("R11 pu_o", pu_o, 0);
        chk("R11 pd_oe", pd_oe, 0);
        chk("R11 lock_o", lock_o, 0);
    endtask

    task automatic t_cmp(input bit lead_ref, input int gap, input bit sw, input string tag);
        bit exp_v;
        swap_sel = sw;
        exp_v = lead_ref ^ sw;
        if (lead_ref) ref_in = 1; else fb_in = 1;
        for (int i = 0; i < gap; i++) begin
            step();
            chk({tag, " do_oe"}, do_oe, 1);
            chk({tag, " do_val"}, do_val, exp_v);
            chk("R5 pu_o", pu_o, exp_v);
            chk("R5 pd_oe", pd_oe, !exp_v);
        end
        if (lead_ref) fb_in = 1; else ref_in = 1;
        step();
        chk("R4 end Z", do_oe, 0);
        chk("R5 end pumps", pu_o | pd_oe, 0);
        ref_in = 0; fb_in = 0;
        step();
    endtask

    task automatic t_coin();
        ref_in = 1; fb_in = 1;
        step();
        chk("R4 coincident Z", do_oe, 0);
        step();
        chk("R4 coincident Z2", do_oe, 0);
        ref_in = 0; fb_in = 0;
        step();
    endtask

    task automatic t_relead();
        swap_sel = 0;
        ref_in = 1;
        step();
        ref_in = 0;
        step();
        ref_in = 1;
        step();
        chk("R6 still driven", do_oe, 1);
        chk("R6 still high", do_val, 1);
        fb_in = 1;
        step();
        chk("R6 ends", do_oe, 0);
        ref_in = 0; fb_in = 0;
        step();
    endtask

    task automatic t_lock();
        t_reset();
        lock_tol = 8'd5;
        for (int k = 0; k < 3; k++) begin
            t_cmp(1'b1, 2, 1'b0, "R1");
            chk("R7 not yet", lock_o, 0);
        end
        t_coin();
        chk("R7 locked", lock_o, 1);
        ref_in = 1;
        for (int i = 1; i <= 7; i++) begin
            step();
            chk("R8 long window", lock_o, (i <= 5) ? 1 : 0);
        end
        fb_in = 1;
        step();
        ref_in = 0; fb_in = 0;
        step();
        t_cmp(1'b1, 4, 1'b0, "R1");
        chk("R8 run restarted", lock_o, 0);
    endtask

    task automatic t_ps();
        swap_sel = 0;
        ref_in = 1;
        step();
        chk("R1 before ps", do_oe, 1);
        run_en = 0;
        step();
        chk("R9 do_oe", do_oe, 0);
        chk("R9 pumps", pu_o | pd_oe, 0);
        chk("R9 lock_o", lock_o, 1);
        fb_in = 1;
        step();
        chk("R9 edge ignored", do_oe, 0);
        fb_in = 0;
        step();
        run_en = 1;
        fb_in = 1;
        step();
        chk("R10 fresh lead oe", do_oe, 1);
        chk("R10 fresh lead val", do_val, 0);
        chk("R10 lock back", lock_o, 0);
        ref_in = 0;
        step();
        ref_in = 1;
        step();
        chk("R10 window closed", do_oe, 0);
        ref_in = 0; fb_in = 0;
        step();
    endtask

    initial begin
        t_reset();
        t_cmp(1'b1, 3, 1'b0, "R1");
        t_cmp(1'b0, 2, 1'b0, "R2");
        t_cmp(1'b1, 2, 1'b1, "R3");
        t_cmp(1'b0, 3, 1'b1, "R3");
        t_coin();
        t_relead();
        t_lock();
        t_ps();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule